// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a clocked master to an external asynchronous static RAM of 512K words by 16 bits. The memory has two byte lanes, each with its own enable. The master issues one request at a time on a request/acknowledge port. Each request carries a 19-bit word address, 16-bit write data, a 2-bit lane mask and a read/write flag. The controller captures the request and runs the memory strobes through a fixed sequence. It then pulses acknowledge once, and for a read it returns the sampled data at the same time.

On the memory side there are two chip selects of opposite polarity, write enable, output enable and two active-low lane enables. The address lines are driven directly. The data bus is split into an output value, a driver enable and an input value, so the tristate pad can sit outside the block.

Every access window is WAIT_CYC clock cycles long. WAIT_CYC is the memory's 55 ns or 70 ns access time divided by the clock period and rounded up, with a minimum of one. The sequence is built so that the controller never enables its data driver while the memory could still be driving the bus.

The finite-state machine has six states:
- ST_IDLE: deselected and quiet.
- ST_RD_ACC: read window.
- ST_RD_END: read acknowledge, memory deselected.
- ST_WR_TURN: bus turnaround before a write.
- ST_WR_PULSE: write-enable pulse.
- ST_WR_HOLD: hold cycle and write acknowledge.

It has these transitions:
- IDLE→RD_ACC on req with wr=0.
- IDLE→WR_TURN on req with wr=1.
- RD_ACC→RD_END when the window ends.
- RD_END→IDLE.
- WR_TURN→WR_PULSE.
- WR_PULSE→WR_HOLD when the window ends.
- WR_HOLD→IDLE.

Top module: `sram_bus_ctl`

## Requirements
- R1: After reset and in idle, the outputs are: mem_cs_n=1, mem_cs=0, mem_oe_n=1, mem_we_n=1, mem_ben_n=2'b11, mem_dq_oe=0 and ack=0. After reset rdata=0.
- R2: mem_cs_n and mem_cs are always opposite. The memory is selected (mem_cs_n=0, mem_cs=1) only during an access, from the first window or turnaround cycle through the hold cycle.
- R3: For a read, mem_oe_n is low and mem_we_n is high for exactly WAIT_CYC cycles. WAIT_CYC is 3 with the default 20 ns clock and 55 ns grade. The bus is sampled on the edge that ends the window, and ack is high in the following cycle. With req sampled at edge 0, ack is seen in cycle WAIT_CYC+1.
- R4: Mask bit be[0] enables the lower lane (bits 7:0, mem_ben_n[0]=0). Mask bit be[1] enables the upper lane (bits 15:8, mem_ben_n[1]=0). A read returns zero on any lane that is not enabled, whatever the bus carries there. A write with mask 2'b00 changes no stored data.
- R5: A write starts with one turnaround cycle in which mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0. Then mem_we_n is low with the driver on for WAIT_CYC cycles. Then comes one hold cycle in which mem_we_n=1, the driver is on, the chip is still selected, and address and data are unchanged. ack is high in the hold cycle, which is cycle WAIT_CYC+2.
- R6: mem_dq_oe is never high while mem_oe_n is low, and it goes high only if mem_oe_n was high in the previous cycle.
- R7: ack is a single-cycle pulse, one per accepted request. The controller returns to idle in the cycle after ack and accepts req only in idle.
- R8: The address, data and mask are captured on the accepting edge. Changes to these master inputs during an access have no effect on mem_addr, mem_dq_o or the lane enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled in idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Word address |
| wdata | input | 16 | Write data |
| be | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, disabled lanes zero |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ben_n | output | 2 | Lane enables, active low |
| mem_addr | output | 19 | Memory address lines |
| mem_dq_o | output | 16 | Data bus output value |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_i | input | 16 | Data bus input value |

## Verification
The hardest case is a read that follows a write at once. In that case the write driver must be off and the turnaround must be respected, so that output enable and the driver never overlap. The stimulus is a table of alternating writes and reads to one location under every lane mask, issued back to back. A bench memory model drives filler bytes on lanes that are not enabled, to show that the masking returns zero. A cycle monitor measures the width of each strobe and the turnaround and hold cycles around every write pulse. The master inputs are scrambled during each access to show they have no effect.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_END,
        ST_WR_TURN,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctl_state_e;

    // whole clock cycles covering a timing figure, at least one
    function automatic int calc_wait(input int t_ns, input int clk_ns);
        int n;
        n = (t_ns + clk_ns - 1) / clk_ns;
        return (n < 1) ? 1 : n;
    endfunction

endpackage

// File: rtl/sram_window_counter.sv
module sram_window_counter #(
    parameter int WAIT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic last
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(WAIT_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (cnt != LAST_VAL)
            cnt <= cnt + 1'b1;
    end

    assign last = !clear && (cnt == LAST_VAL);

    // R3: window length never exceeds the configured count
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_VAL);

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] bus_in,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DW = LANES * LANE_W;

    logic [DW-1:0] masked;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign masked[i*LANE_W +: LANE_W] = lane_en[i] ? bus_in[i*LANE_W +: LANE_W] : '0;

        // R4: a disabled lane reads back as zero
        a_r4_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (cap && !lane_en[i]) |=> (rdata[i*LANE_W +: LANE_W] == '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (cap)
            rdata <= masked;
    end

endmodule

// File: rtl/sram_bus_ctl.sv
module sram_bus_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int LANE_W   = 8,
    parameter int LANES    = 2,
    parameter int CLK_NS   = 20,
    parameter int GRADE_NS = 55
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic                    wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        be,
    output logic                    ack,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    mem_cs_n,
    output logic                    mem_cs,
    output logic                    mem_we_n,
    output logic                    mem_oe_n,
    output logic [LANES-1:0]        mem_ben_n,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LANES*LANE_W-1:0] mem_dq_o,
    output logic                    mem_dq_oe,
    input  logic [LANES*LANE_W-1:0] mem_dq_i
);
    localparam int DATA_W   = LANES * LANE_W;
    localparam int WAIT_CYC = calc_wait(GRADE_NS, CLK_NS);

    ctl_state_e state, nxt;

    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic [LANES-1:0]  cmd_be;
    logic              win_clear;
    logic              win_last;
    logic              rd_cap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // command capture on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_addr  <= '0;
            cmd_wdata <= '0;
            cmd_be    <= '0;
        end else if (state == ST_IDLE && req) begin
            cmd_addr  <= addr;
            cmd_wdata <= wdata;
            cmd_be    <= be;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (req) nxt = wr ? ST_WR_TURN : ST_RD_ACC;
            ST_RD_ACC:   if (win_last) nxt = ST_RD_END;
            ST_RD_END:   nxt = ST_IDLE;
            ST_WR_TURN:  nxt = ST_WR_PULSE;
            ST_WR_PULSE: if (win_last) nxt = ST_WR_HOLD;
            ST_WR_HOLD:  nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        mem_cs_n  = 1'b1;
        mem_cs    = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_ben_n = '1;
        mem_dq_oe = 1'b0;
        ack       = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RD_ACC: begin
                mem_cs_n  = 1'b0;
                mem_cs    = 1'b1;
                mem_ben_n = ~cmd_be;
                mem_oe_n  = 1'b0;
            end
            ST_RD_END: ack = 1'b1;
            ST_WR_TURN: begin
                mem_cs_n  = 1'b0;
                mem_cs    = 1'b1;
                mem_ben_n = ~cmd_be;
            end
            ST_WR_PULSE: begin
                mem_cs_n  = 1'b0;
                mem_cs    = 1'b1;
                mem_ben_n = ~cmd_be;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                mem_cs_n  = 1'b0;
                mem_cs    = 1'b1;
                mem_ben_n = ~cmd_be;
                mem_dq_oe = 1'b1;
                ack       = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr  = cmd_addr;
    assign mem_dq_o  = cmd_wdata;
    assign win_clear = !(state == ST_RD_ACC || state == ST_WR_PULSE);
    assign rd_cap    = (state == ST_RD_ACC) && win_last;

    sram_window_counter #(.WAIT_CYC(WAIT_CYC)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (win_clear),
        .last  (win_last)
    );

    sram_lane_capture #(.LANE_W(LANE_W), .LANES(LANES)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (rd_cap),
        .lane_en (cmd_be),
        .bus_in  (mem_dq_i),
        .rdata   (rdata)
    );

    // R2: the two selects always agree
    a_r2_select_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n != mem_cs);

    // R3: reading means write strobe high and driver off
    a_r3_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

    // R6: driver only after output enable was already high
    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

    // R5: hold cycle after the write pulse keeps address and data
    a_r5_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $rose(mem_we_n)) |->
            (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o)));

    // R7: acknowledge is a single pulse
    a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R8: captured command stays put through an access
    a_r8_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_ben_n)));

endmodule

// File: tb/tb_sram_bus_ctl.sv
module tb_sram_bus_ctl;

    localparam int WAIT_CYC = 3;   // 55 ns over a 20 ns clock, rounded up
    localparam int NVEC     = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [18:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  be = '0;
    logic        ack;
    logic [15:0] rdata;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_ben_n;
    logic [18:0] mem_addr;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sram_bus_ctl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .be(be), .ack(ack), .rdata(rdata),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_ben_n(mem_ben_n), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    // small memory model: low six address bits, filler on masked lanes
    logic [15:0] mem [64];
    logic        sel;
    assign sel = !mem_cs_n && mem_cs;
    assign mem_dq_i = (sel && !mem_oe_n && mem_we_n) ?
        { mem_ben_n[1] ? 8'hA5 : mem[mem_addr[5:0]][15:8],
          mem_ben_n[0] ? 8'h5A : mem[mem_addr[5:0]][7:0] } : 16'hDEAD;

    initial for (int i = 0; i < 64; i++) mem[i] = '0;

    always @(posedge clk) begin
        if (sel && !mem_we_n && mem_dq_oe) begin
            if (!mem_ben_n[0]) mem[mem_addr[5:0]][7:0]  <= mem_dq_o[7:0];
            if (!mem_ben_n[1]) mem[mem_addr[5:0]][15:8] <= mem_dq_o[15:8];
        end
    end

    // strobe monitor
    int   oe_run = 0, we_run = 0;
    logic p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
    logic [18:0] p_addr = '0;
    logic [15:0] p_dq = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe)
                chk(mem_oe_n && p_oe_n, "R6 driver vs oe_n", {mem_oe_n, p_oe_n}, 2'b11);
            if (!mem_oe_n) oe_run++;
            else if (!p_oe_n) begin
                chk(oe_run == WAIT_CYC, "R3 oe_n low width", oe_run, WAIT_CYC);
                oe_run = 0;
            end
            if (!mem_we_n) begin
                if (p_we_n)
                    chk(!p_dq_oe && p_oe_n, "R5 turnaround before pulse", {p_dq_oe, p_oe_n}, 2'b01);
                we_run++;
            end else if (!p_we_n) begin
                chk(we_run == WAIT_CYC, "R5 we_n low width", we_run, WAIT_CYC);
                chk(sel && mem_dq_oe && mem_addr == p_addr && mem_dq_o == p_dq,
                    "R5 hold cycle", {sel, mem_dq_oe}, 2'b11);
                we_run = 0;
            end
        end
        p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe;
        p_addr = mem_addr; p_dq = mem_dq_o;
    end

    task automatic chk_idle(input string rq);
        chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && mem_ben_n == 2'b11
            && !mem_dq_oe && !ack, rq,
            {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_ben_n, mem_dq_oe, ack}, 8'b10111100);
    endtask

    // one access: returns read data and ack latency in cycles
    task automatic access(input logic w, input logic [1:0] m, input logic [18:0] a,
                          input logic [15:0] d, output logic [15:0] rd, output int lat);
        @(negedge clk);
        req = 1'b1; wr = w; be = m; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = ~w; be = ~m; addr = ~a; wdata = ~d;   // R8 scramble
        lat = 1;
        while (!ack && lat < 20) begin
            if (sel) begin
                chk(mem_addr == a, "R8 address held", mem_addr, a);
                chk(mem_ben_n == ~m, "R4 lane enables", mem_ben_n, ~m);
            end
            if (mem_dq_oe) chk(mem_dq_o == d, "R8 data held", mem_dq_o, d);
            @(negedge clk);
            lat++;
        end
        rd = rdata;
        @(negedge clk);
        chk_idle("R7 idle after ack");
    endtask

    // {wr, be, addr, wdata, expected rdata}
    localparam logic [53:0] VECS [NVEC] = '{
        {1'b1, 2'b11, 19'h00005, 16'h1234, 16'h0000},
        {1'b0, 2'b11, 19'h00005, 16'h0000, 16'h1234},
        {1'b1, 2'b01, 19'h00005, 16'hABCD, 16'h0000},
        {1'b0, 2'b11, 19'h00005, 16'h0000, 16'h12CD},
        {1'b1, 2'b10, 19'h00005, 16'h77EE, 16'h0000},
        {1'b0, 2'b11, 19'h00005, 16'h0000, 16'h77CD},
        {1'b0, 2'b01, 19'h00005, 16'h0000, 16'h00CD},
        {1'b0, 2'b10, 19'h00005, 16'h0000, 16'h7700},
        {1'b1, 2'b00, 19'h00005, 16'hFFFF, 16'h0000},
        {1'b0, 2'b11, 19'h00005, 16'h0000, 16'h77CD},
        {1'b1, 2'b11, 19'h0003F, 16'h5A5A, 16'h0000},
        {1'b0, 2'b11, 19'h0003F, 16'h0000, 16'h5A5A},
        {1'b0, 2'b11, 19'h7FFC5, 16'h0000, 16'h77CD}
    };

    bit done = 1'b0;

    initial begin
        logic [15:0] rd;
        int lat;
        repeat (3) @(negedge clk);
        chk_idle("R1 outputs in reset");
        chk(rdata == 16'h0, "R1 rdata in reset", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 idle after reset");

        for (int v = 0; v < NVEC; v++) begin
            logic [53:0] e;
            e = VECS[v];
            access(e[53], e[52:51], e[50:32], e[31:16], rd, lat);
            if (e[53]) begin
                chk(lat == WAIT_CYC + 2, "R5 write ack latency", lat, WAIT_CYC + 2);
            end else begin
                chk(lat == WAIT_CYC + 1, "R3 read ack latency", lat, WAIT_CYC + 1);
                chk(rd == e[15:0], "R4 read data", rd, e[15:0]);
            end
        end

        // R7: a request held for only one cycle yields a single ack
        access(1'b0, 2'b11, 19'h00005, 16'h0, rd, lat);
        repeat (6) begin
            @(negedge clk);
            chk(!ack && mem_cs_n, "R7 no extra access", {ack, mem_cs_n}, 2'b01);
        end

        // R2: selects stay opposite while idle
        chk(mem_cs_n == !mem_cs, "R2 select pair", {mem_cs_n, mem_cs}, 2'b10);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule